// File: doc/BRIEF.md
# I2C Master Event Flags, Interrupt and DMA Request Unit

This unit sits beside the byte sequencer of an I2C master. The sequencer reports four kinds of byte-level events as single-cycle pulses: data transfer end, the WAIT point just before the acknowledge clock, a missing acknowledge, and lost arbitration. The unit latches each pulse into a sticky flag. Software clears the flags through a small byte-wide register port. Each flag is gated by its own enable bit, and the results are combined into one registered interrupt line. A pending WAIT flag holds the clock line low until software clears the flag, so software can pace each acknowledge.

The same enable register holds two DMA enables and the ninth bit of each SCL count. When transmit DMA is on, every pulse that reports an empty data register produces a one-cycle transmit request. When receive DMA is on, every received byte produces a one-cycle receive request. The two 9-bit SCL counts, low period and high period, are assembled from the low and high count registers plus the bit-8 fields, and are forwarded to the timing generator. While the module enable input is low, all stored state is held at zero.

Top module: `i2c_irq_dma_unit`

## Requirements
- R1: While `mod_en` is 0, the flags, the enable register, both count registers, `irq`, `scl_hold` and both DMA requests are 0 from the following clock edge, and event pulses and register writes made in that state are lost.
- R2: A read at offset 0x08 returns {bit7 `scl_in`, bit6 `sda_in`, bit5 0, bit4 `bus_busy`, bit3 arbitration-lost flag, bit2 missing-acknowledge flag, bit1 WAIT flag, bit0 transfer-end flag}. The three line monitors follow their inputs in the same cycle.
- R3: An event pulse sets its flag at the next clock edge, and the flag stays set until software clears it.
- R4: A write to offset 0x08 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. Data bits 7 to 4 of that write have no effect.
- R5: When an event pulse and a write that clears the same flag fall in the same cycle, the flag ends up set.
- R6: `irq` is a register: one cycle after the flags and enables take a value, it equals the OR over bits 0 to 3 of (flag AND enable).
- R7: Offset 0x0C reads back the enable register: bit7 low-count bit 8, bit6 high-count bit 8, bit5 transmit DMA enable, bit4 receive DMA enable, bits 3 to 0 the interrupt enables for arbitration lost, missing acknowledge, WAIT and transfer end.
- R8: `scl_low_cnt` is {enable bit7, register 0x10} and `scl_high_cnt` is {enable bit6, register 0x14}. Both count registers read back their written value.
- R9: `scl_hold` is 1 exactly while the WAIT flag is set.
- R10: A `tx_empty` pulse with transmit DMA enabled gives a one-cycle `dma_tx_req` in the next cycle. With transmit DMA disabled, no request is made.
- R11: A `rx_full` pulse with receive DMA enabled gives a one-cycle `dma_rx_req` in the next cycle. With receive DMA disabled, no request is made.
- R12: Offsets 0x00, 0x04 and every unlisted offset read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Module enable from the control register; 0 clears all state |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| evt_dte | input | 1 | Pulse: data transfer end |
| evt_wait | input | 1 | Pulse: eighth bit done, acknowledge clock pending |
| evt_nack | input | 1 | Pulse: acknowledge not received |
| evt_al | input | 1 | Pulse: arbitration lost |
| scl_in | input | 1 | Live SCL level |
| sda_in | input | 1 | Live SDA level |
| bus_busy | input | 1 | Bus busy level from the sequencer |
| tx_empty | input | 1 | Pulse: data register emptied |
| rx_full | input | 1 | Pulse: byte received into data register |
| irq | output | 1 | Registered interrupt request |
| scl_hold | output | 1 | Hold SCL low before the acknowledge clock |
| dma_tx_req | output | 1 | Transmit DMA request strobe |
| dma_rx_req | output | 1 | Receive DMA request strobe |
| scl_low_cnt | output | 9 | SCL low period count |
| scl_high_cnt | output | 9 | SCL high period count |

## Verification
The properties assume that every event, `tx_empty` and `rx_full` input is a pulse sampled on a single clock edge, and that the register port presents at most one write per cycle with a stable address. The stimulus drives all inputs on the falling edge, raises each pulse for exactly one cycle, and changes `mod_en` only between register accesses. Under those assumptions, the flag clear-versus-set priority and the one-cycle latency of the request strobes can be checked edge by edge.

// File: rtl/i2cis_pkg.sv
package i2cis_pkg;

  localparam int DATA_W = 8;
  localparam int CNT_W  = DATA_W + 1;
  localparam int NUM_EV = 4;

  // register byte offsets
  localparam int OFS_DATA = 'h00;
  localparam int OFS_CTRL = 'h04;
  localparam int OFS_STS  = 'h08;
  localparam int OFS_ENA  = 'h0C;
  localparam int OFS_LOW  = 'h10;
  localparam int OFS_HIGH = 'h14;

  // status bit positions
  localparam int ST_SCL  = 7;
  localparam int ST_SDA  = 6;
  localparam int ST_BUSY = 4;

  // event flag positions (shared by status and enable registers)
  localparam int EV_DTE  = 0;
  localparam int EV_WAIT = 1;
  localparam int EV_NACK = 2;
  localparam int EV_AL   = 3;

  // enable register upper fields
  localparam int EN_LOW8  = 7;
  localparam int EN_HIGH8 = 6;
  localparam int EN_TXD   = 5;
  localparam int EN_RXD   = 4;

  // flag update: a new event always wins over a clearing write
  function automatic logic [NUM_EV-1:0] flag_update(
    input logic [NUM_EV-1:0] cur,
    input logic [NUM_EV-1:0] set,
    input logic              wr_sts,
    input logic [NUM_EV-1:0] keep_mask
  );
    logic [NUM_EV-1:0] kept;
    kept = wr_sts ? (cur & keep_mask) : cur;
    return set | kept;
  endfunction

  function automatic logic irq_any(
    input logic [NUM_EV-1:0] flags,
    input logic [NUM_EV-1:0] ena
  );
    return |(flags & ena);
  endfunction

  function automatic logic [CNT_W-1:0] join_cnt(
    input logic              msb,
    input logic [DATA_W-1:0] low
  );
    return {msb, low};
  endfunction

  function automatic logic [DATA_W-1:0] status_word(
    input logic              scl,
    input logic              sda,
    input logic              busy,
    input logic [NUM_EV-1:0] flags
  );
    logic [DATA_W-1:0] w;
    w = '0;
    w[ST_SCL]  = scl;
    w[ST_SDA]  = sda;
    w[ST_BUSY] = busy;
    w[NUM_EV-1:0] = flags;
    return w;
  endfunction

endpackage

// File: rtl/i2cis_flags.sv
module i2cis_flags
  import i2cis_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic [NUM_EV-1:0] evt,
  input  logic              wr_sts,
  input  logic [NUM_EV-1:0] keep_mask,
  output logic [NUM_EV-1:0] flg_q
);

  logic [NUM_EV-1:0] flg_d;

  always_comb begin
    flg_d = flag_update(flg_q, evt, wr_sts, keep_mask);
    if (!mod_en) flg_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

endmodule

// File: rtl/i2cis_cfg.sv
module i2cis_cfg
  import i2cis_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              wr_ena,
  input  logic              wr_low,
  input  logic              wr_high,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q,
  output logic [DATA_W-1:0] low_q,
  output logic [DATA_W-1:0] high_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (!mod_en) begin
      en_q   <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else begin
      if (wr_ena)  en_q   <= wdata;
      if (wr_low)  low_q  <= wdata;
      if (wr_high) high_q <= wdata;
    end
  end

endmodule

// File: rtl/i2cis_dma.sv
module i2cis_dma #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] trig,
  output logic [NUM_CH-1:0] req
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req[c] <= 1'b0;
      else        req[c] <= mod_en & ch_en[c] & trig[c];
    end
  end

endmodule

// File: rtl/i2c_irq_dma_unit.sv
module i2c_irq_dma_unit
  import i2cis_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              evt_dte,
  input  logic              evt_wait,
  input  logic              evt_nack,
  input  logic              evt_al,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              bus_busy,
  input  logic              tx_empty,
  input  logic              rx_full,
  output logic              irq,
  output logic              scl_hold,
  output logic              dma_tx_req,
  output logic              dma_rx_req,
  output logic [8:0]        scl_low_cnt,
  output logic [8:0]        scl_high_cnt
);

  localparam int DMA_CH = 2;

  // address decode, brought out as named wires
  logic sel_sts, sel_ena, sel_low, sel_high;
  logic wr_sts, wr_ena, wr_low, wr_high;

  assign sel_sts  = (reg_addr == ADDR_W'(OFS_STS));
  assign sel_ena  = (reg_addr == ADDR_W'(OFS_ENA));
  assign sel_low  = (reg_addr == ADDR_W'(OFS_LOW));
  assign sel_high = (reg_addr == ADDR_W'(OFS_HIGH));
  assign wr_sts   = reg_wr & sel_sts;
  assign wr_ena   = reg_wr & sel_ena;
  assign wr_low   = reg_wr & sel_low;
  assign wr_high  = reg_wr & sel_high;

  logic [NUM_EV-1:0] evt_vec;
  always_comb begin
    evt_vec          = '0;
    evt_vec[EV_DTE]  = evt_dte;
    evt_vec[EV_WAIT] = evt_wait;
    evt_vec[EV_NACK] = evt_nack;
    evt_vec[EV_AL]   = evt_al;
  end

  logic [NUM_EV-1:0] flg_q;
  logic [DATA_W-1:0] en_q, low_q, high_q;

  i2cis_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .evt       (evt_vec),
    .wr_sts    (wr_sts),
    .keep_mask (reg_wdata[NUM_EV-1:0]),
    .flg_q     (flg_q)
  );

  i2cis_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_en  (mod_en),
    .wr_ena  (wr_ena),
    .wr_low  (wr_low),
    .wr_high (wr_high),
    .wdata   (reg_wdata),
    .en_q    (en_q),
    .low_q   (low_q),
    .high_q  (high_q)
  );

  logic [DMA_CH-1:0] dma_en, dma_trig, dma_req;
  assign dma_en   = {en_q[EN_RXD], en_q[EN_TXD]};
  assign dma_trig = {rx_full, tx_empty};

  i2cis_dma #(.NUM_CH(DMA_CH)) u_dma (
    .clk    (clk),
    .rst_n  (rst_n),
    .mod_en (mod_en),
    .ch_en  (dma_en),
    .trig   (dma_trig),
    .req    (dma_req)
  );

  assign dma_tx_req = dma_req[0];
  assign dma_rx_req = dma_req[1];

  // registered interrupt
  logic irq_d;
  assign irq_d = mod_en & irq_any(flg_q, en_q[NUM_EV-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  assign scl_hold     = flg_q[EV_WAIT];
  assign scl_low_cnt  = join_cnt(en_q[EN_LOW8], low_q);
  assign scl_high_cnt = join_cnt(en_q[EN_HIGH8], high_q);

  always_comb begin
    reg_rdata = '0;
    if (sel_sts)  reg_rdata = status_word(scl_in, sda_in, bus_busy, flg_q);
    if (sel_ena)  reg_rdata = en_q;
    if (sel_low)  reg_rdata = low_q;
    if (sel_high) reg_rdata = high_q;
  end

endmodule

// File: rtl/i2cis_chk.sv
module i2cis_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mod_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic              evt_dte,
  input logic              evt_wait,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              irq,
  input logic              scl_hold,
  input logic              dma_tx_req,
  input logic              dma_rx_req,
  input logic [3:0]        flg_q,
  input logic [7:0]        en_q
);

  logic sts_write;
  assign sts_write = reg_wr && (reg_addr == ADDR_W'(8));

  // R1
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (flg_q == 4'h0 && en_q == 8'h00 && !irq && !dma_tx_req && !dma_rx_req));

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && flg_q[2] && !sts_write) |=> flg_q[2]);

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_write && !reg_wdata[0] && !evt_dte) |=> !flg_q[0]);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && evt_dte) |=> flg_q[0]);

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && |(flg_q & en_q[3:0])) |=> irq);

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flg_q & en_q[3:0])) |=> !irq);

  // R9
  hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && evt_wait) |=> scl_hold);

  // R10
  tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && en_q[5] && tx_empty) |=> dma_tx_req);

  // R10
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_q[5] && tx_empty) |=> !dma_tx_req);

  // R11
  rx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && en_q[4] && rx_full) |=> dma_rx_req);

  // R11
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_q[4] && rx_full) |=> !dma_rx_req);

endmodule

bind i2c_irq_dma_unit i2cis_chk #(.ADDR_W(ADDR_W)) u_i2cis_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mod_en     (mod_en),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .evt_dte    (evt_dte),
  .evt_wait   (evt_wait),
  .tx_empty   (tx_empty),
  .rx_full    (rx_full),
  .irq        (irq),
  .scl_hold   (scl_hold),
  .dma_tx_req (dma_tx_req),
  .dma_rx_req (dma_rx_req),
  .flg_q      (flg_q),
  .en_q       (en_q)
);

// File: tb/test_i2c_irq_dma_unit.sv
module test_i2c_irq_dma_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mod_en = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       evt_dte = 0, evt_wait = 0, evt_nack = 0, evt_al = 0;
  logic       scl_in = 1, sda_in = 1, bus_busy = 0;
  logic       tx_empty = 0, rx_full = 0;
  logic       irq, scl_hold, dma_tx_req, dma_rx_req;
  logic [8:0] scl_low_cnt, scl_high_cnt;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  i2c_irq_dma_unit #(.ADDR_W(5)) i_i2c_irq_dma_unit (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_dte(evt_dte), .evt_wait(evt_wait), .evt_nack(evt_nack), .evt_al(evt_al),
    .scl_in(scl_in), .sda_in(sda_in), .bus_busy(bus_busy),
    .tx_empty(tx_empty), .rx_full(rx_full),
    .irq(irq), .scl_hold(scl_hold), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
    .scl_low_cnt(scl_low_cnt), .scl_high_cnt(scl_high_cnt)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_evt(input logic [3:0] f);
    {evt_al, evt_nack, evt_wait, evt_dte} = f;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] exp_sts(input logic s, input logic d, input logic b, input logic [3:0] f);
    return (8'(s) << 7) + (8'(d) << 6) + (8'(b) << 4) + 8'(f);
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mod_en = 1'b1;
    tick();

    // R1 reset state
    rd(5'h08, r); chk(r == 8'hC0, "R1 reset status", r, 8'hC0);
    rd(5'h0C, r); chk(r == 8'h00, "R1 reset enables", r, 0);
    chk(!irq && !scl_hold && !dma_tx_req && !dma_rx_req, "R1 reset outputs",
        {irq, scl_hold, dma_tx_req, dma_rx_req}, 0);
    chk(scl_low_cnt == 0 && scl_high_cnt == 0, "R1 reset counts", scl_low_cnt, 0);

    // R2 live monitors sweep
    for (int m = 0; m < 8; m++) begin
      {scl_in, sda_in, bus_busy} = 3'(m);
      rd(5'h08, r);
      chk(r == exp_sts(scl_in, sda_in, bus_busy, 4'h0), "R2 monitors", r,
          exp_sts(scl_in, sda_in, bus_busy, 4'h0));
    end
    {scl_in, sda_in, bus_busy} = 3'b101;

    // R3 R6 R7 exhaustive flags x enables
    for (int f = 0; f < 16; f++) begin
      for (int e = 0; e < 16; e++) begin
        wr(5'h08, 8'h00);
        set_evt(4'(f));
        reg_addr = 5'h0C; reg_wdata = 8'(e); reg_wr = 1'b1;
        tick();
        set_evt(4'h0); reg_wr = 1'b0;
        tick();
        chk(irq == ((f & e) != 0), "R6 irq combine", irq, ((f & e) != 0));
        if (e == 5) begin
          rd(5'h08, r);
          chk(r == exp_sts(1, 0, 1, 4'(f)), "R3 flags latched", r, exp_sts(1, 0, 1, 4'(f)));
          rd(5'h0C, r);
          chk(r == 8'(e), "R7 enable readback", r, e);
          chk(scl_hold == f[1], "R9 hold follows wait", scl_hold, f[1]);
        end
      end
    end

    // R4 clear masks, upper data bits ignored
    for (int p = 0; p < 16; p++) begin
      set_evt(4'hF); tick(); set_evt(4'h0);
      wr(5'h08, 8'hF0 | 8'(p));
      rd(5'h08, r);
      chk(r == exp_sts(1, 0, 1, 4'(p)), "R4 write-zero clear", r, exp_sts(1, 0, 1, 4'(p)));
    end
    wr(5'h08, 8'h00);
    chk(!scl_hold, "R9 hold released", scl_hold, 0);

    // R5 event beats clear
    evt_dte = 1'b1;
    wr(5'h08, 8'h00);
    evt_dte = 1'b0;
    rd(5'h08, r);
    chk(r[0] == 1'b1, "R5 set wins", r[0], 1);
    wr(5'h08, 8'h00);

    // R10 R11 DMA strobes
    wr(5'h0C, 8'h20);
    tx_empty = 1'b1; rx_full = 1'b1; tick(); tx_empty = 1'b0; rx_full = 1'b0;
    chk(dma_tx_req == 1'b1, "R10 tx request", dma_tx_req, 1);
    chk(dma_rx_req == 1'b0, "R11 rx disabled", dma_rx_req, 0);
    tick();
    chk(dma_tx_req == 1'b0, "R10 tx one cycle", dma_tx_req, 0);
    wr(5'h0C, 8'h10);
    tx_empty = 1'b1; rx_full = 1'b1; tick(); tx_empty = 1'b0; rx_full = 1'b0;
    chk(dma_rx_req == 1'b1, "R11 rx request", dma_rx_req, 1);
    chk(dma_tx_req == 1'b0, "R10 tx disabled", dma_tx_req, 0);
    tick();
    chk(dma_rx_req == 1'b0, "R11 rx one cycle", dma_rx_req, 0);

    // R8 count assembly sweep
    for (int k = 0; k < 16; k++) begin
      logic [7:0] lo, hi;
      lo = 8'(k * 17 + 3); hi = ~lo;
      wr(5'h10, lo); wr(5'h14, hi);
      wr(5'h0C, {k[0], k[1], 6'h00});
      chk(scl_low_cnt == {k[0], lo}, "R8 low count", scl_low_cnt, {k[0], lo});
      chk(scl_high_cnt == {k[1], hi}, "R8 high count", scl_high_cnt, {k[1], hi});
      rd(5'h10, r); chk(r == lo, "R8 low readback", r, lo);
    end

    // R12 unmapped offsets
    wr(5'h0C, 8'h3C); wr(5'h10, 8'h5A); wr(5'h14, 8'hA5);
    wr(5'h00, 8'hFF); wr(5'h04, 8'hFF); wr(5'h18, 8'hFF); wr(5'h1C, 8'hFF);
    rd(5'h00, r); chk(r == 0, "R12 read 0x00", r, 0);
    rd(5'h04, r); chk(r == 0, "R12 read 0x04", r, 0);
    rd(5'h18, r); chk(r == 0, "R12 read 0x18", r, 0);
    rd(5'h0C, r); chk(r == 8'h3C, "R12 enable intact", r, 8'h3C);
    rd(5'h10, r); chk(r == 8'h5A, "R12 low intact", r, 8'h5A);
    rd(5'h14, r); chk(r == 8'hA5, "R12 high intact", r, 8'hA5);
    rd(5'h08, r); chk(r[3:0] == 0, "R12 flags intact", r[3:0], 0);

    // R1 module disable clears and ignores
    set_evt(4'hF); tick(); set_evt(4'h0); tick();
    chk(irq == 1'b1, "R1 irq before disable", irq, 1);
    mod_en = 1'b0;
    set_evt(4'hF);
    wr(5'h0C, 8'hFF);
    set_evt(4'h0);
    chk(!irq && !scl_hold && scl_low_cnt == 0 && scl_high_cnt == 0, "R1 disabled outputs",
        {irq, scl_hold, scl_low_cnt}, 0);
    mod_en = 1'b1;
    rd(5'h08, r); chk(r[3:0] == 0, "R1 flags cleared", r[3:0], 0);
    rd(5'h0C, r); chk(r == 0, "R1 enables cleared", r, 0);
    rd(5'h14, r); chk(r == 0, "R1 high cleared", r, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule